// File: doc/BRIEF.md
# Stereo DC Offset Removal with Freeze

This stage sits in an audio ADC path after the decimation filter and runs once per output sample. Each of the two channels keeps its own estimate of the DC level riding on its signal. That estimate is subtracted from every sample, and the result is clamped to the signed sample range. The estimate is a first-order leaky integrator with shift constant K. Each step moves the estimate toward the current sample by `(x*2^K - est) >> K`. It is stored with K fraction bits below the integer sample bits.

Two control bits choose the mode. With tracking enabled, the estimate learns and is subtracted. With freeze set, the learned value is held but is still subtracted, so the stage acts as a fixed offset corrector. This supports a system calibration: the system runs with tracking on until the estimate settles, then sets freeze. With tracking off and freeze clear, samples pass through unchanged and the estimate keeps its value.

Top module: `dc_trim_stereo`

## Requirements
- R1: In tracking mode (`track_en`=1, `freeze`=0), each accepted sample gives output `sat(x - floor(est/2^K))`, where `est` is the value held before this sample. The estimate then becomes `est + floor((x*2^K - est)/2^K)`. `est` is a fixed-point value with K fraction bits.
- R2: The output is saturated to the signed DW-bit range instead of wrapping. For DW=24 this range is -8388608 to 8388607.
- R3: The two channels are independent. Channel A's estimate depends only on `in_a`, and channel B's estimate depends only on `in_b`.
- R4: While `freeze`=1, the estimate does not change, whatever `track_en` is. The held integer estimate is still subtracted, and the result is saturated.
- R5: With `track_en`=0 and `freeze`=0, the output equals the input exactly and the estimate is held.
- R6: A synchronous active-high `rst` clears both estimates to zero. On the clock after `rst` is high, `out_valid` is low and both outputs are zero.
- R7: `out_valid` is high exactly one clock after each clock in which `in_valid` is high, and low otherwise. Between samples the outputs keep their last value.
- R8: The mode bits are sampled only on clocks where `in_valid` is high. Without a sample, neither estimate nor output changes, so a mode change applies from the next sample on.
- R9: After tracking a constant DC level with small alternating noise for several time constants, the output is the noise with the DC level removed, and freezing keeps that correction in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One decimated sample pair present this clock |
| track_en | input | 1 | Enable estimate learning and subtraction |
| freeze | input | 1 | Hold estimates while still subtracting them |
| in_a | input | DW (24) | Channel A sample, signed |
| in_b | input | DW (24) | Channel B sample, signed |
| out_valid | output | 1 | Corrected sample pair present this clock |
| out_a | output | DW (24) | Channel A corrected sample, signed |
| out_b | output | DW (24) | Channel B corrected sample, signed |

## Verification
The assertions check several rules on every cycle. The valid strobe follows the input strobe with a one-clock lag. Both estimates stay put on idle clocks and in freeze and bypass modes. Bypass outputs copy the inputs, and reset clears the state. Only the bench's reference model can show the arithmetic: the exact rounding of the integrator update, the subtraction of the pre-update estimate, saturation at both rails, settling on a DC level and independence between channels. The scenarios drive long settling runs, freezes at large offsets and mode changes between samples.

// File: rtl/dctrim_pkg.sv
package dctrim_pkg;

    localparam int SAMPLE_W_DEF = 24;
    localparam int SHIFT_K_DEF  = 12;
    localparam int NUM_CH       = 2;

    typedef enum logic [1:0] {
        MODE_TRACK  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_BYPASS = 2'd2
    } trim_mode_e;

    typedef struct packed {
        logic       load;
        trim_mode_e mode;
    } trim_ctl_t;

    function automatic trim_mode_e decode_mode(input logic en, input logic frz);
        if (frz)
            return MODE_HOLD;
        else if (en)
            return MODE_TRACK;
        else
            return MODE_BYPASS;
    endfunction

endpackage

// File: rtl/dctrim_ctrl.sv
module dctrim_ctrl
    import dctrim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      track_en,
    input  logic      freeze,
    output trim_ctl_t ctl,
    output logic      out_valid
);

    always_comb begin
        ctl.load = in_valid;
        ctl.mode = decode_mode(track_en, freeze);
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

endmodule

// File: rtl/dctrim_chan.sv
module dctrim_chan
    import dctrim_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int K  = SHIFT_K_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  trim_ctl_t            ctl,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y,
    output logic signed [DW:0]   est_int
);

    localparam int EW = DW + K + 1;
    localparam int SW = DW + 2;

    logic signed [EW-1:0] est_q;
    logic signed [EW-1:0] est_d;
    logic signed [EW-1:0] x_fix;
    logic signed [EW:0]   diff;
    logic signed [SW-1:0] sub;
    logic signed [DW-1:0] sat_y;
    logic signed [DW-1:0] y_d;
    logic                 ovf;

    assign x_fix   = {x[DW-1], x, {K{1'b0}}};
    assign diff    = {x_fix[EW-1], x_fix} - {est_q[EW-1], est_q};
    assign est_d   = est_q + EW'(diff >>> K);
    assign est_int = est_q[EW-1:K];
    assign sub     = {{2{x[DW-1]}}, x} - {est_int[DW], est_int};

    always_comb begin
        ovf = (sub[SW-1:DW-1] != {(SW-DW+1){1'b0}}) &&
              (sub[SW-1:DW-1] != {(SW-DW+1){1'b1}});
        if (!ovf)
            sat_y = sub[DW-1:0];
        else if (sub[SW-1])
            sat_y = {1'b1, {(DW-1){1'b0}}};
        else
            sat_y = {1'b0, {(DW-1){1'b1}}};
    end

    always_comb begin
        unique case (ctl.mode)
            MODE_TRACK,
            MODE_HOLD:   y_d = sat_y;
            default:     y_d = x;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est_q <= '0;
            y     <= '0;
        end else if (ctl.load) begin
            y <= y_d;
            if (ctl.mode == MODE_TRACK)
                est_q <= est_d;
        end
    end

endmodule

// File: rtl/dc_trim_stereo.sv
module dc_trim_stereo
    import dctrim_pkg::*;
#(
    parameter int DW = SAMPLE_W_DEF,
    parameter int K  = SHIFT_K_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 track_en,
    input  logic                 freeze,
    input  logic signed [DW-1:0] in_a,
    input  logic signed [DW-1:0] in_b,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_a,
    output logic signed [DW-1:0] out_b
);

    trim_ctl_t            ctl;
    logic signed [DW-1:0] xs      [NUM_CH];
    logic signed [DW-1:0] ys      [NUM_CH];
    logic signed [DW:0]   est_int [NUM_CH];

    assign xs[0] = in_a;
    assign xs[1] = in_b;
    assign out_a = ys[0];
    assign out_b = ys[1];

    dctrim_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .track_en  (track_en),
        .freeze    (freeze),
        .ctl       (ctl),
        .out_valid (out_valid)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dctrim_chan #(.DW(DW), .K(K)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .x       (xs[c]),
            .y       (ys[c]),
            .est_int (est_int[c])
        );
    end

endmodule

// File: rtl/dc_trim_stereo_chk.sv
module dc_trim_stereo_chk #(
    parameter int DW = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 track_en,
    input logic                 freeze,
    input logic signed [DW-1:0] in_a,
    input logic signed [DW-1:0] in_b,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_a,
    input logic signed [DW-1:0] out_b,
    input logic signed [DW:0]   est_a,
    input logic signed [DW:0]   est_b
);

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(est_a) && $stable(est_b) && $stable(out_a) && $stable(out_b)));

    a_r4_freeze_holds_est: assert property (@(posedge clk) disable iff (rst)
        (in_valid && freeze) |=> ($stable(est_a) && $stable(est_b)));

    a_r5_bypass_copies: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !track_en && !freeze) |=>
            (out_a == $past(in_a) && out_b == $past(in_b) && $stable(est_a) && $stable(est_b)));

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && est_a == '0 && est_b == '0 && out_a == '0 && out_b == '0));

endmodule

bind dc_trim_stereo dc_trim_stereo_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .track_en  (track_en),
    .freeze    (freeze),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b),
    .est_a     (est_int[0]),
    .est_b     (est_int[1])
);

// File: tb/dc_trim_stereo_bench.sv
`timescale 1ns/1ps
module dc_trim_stereo_bench;

    localparam int DW = 24;
    localparam int K  = 12;
    localparam longint SMAX = (64'sd1 <<< (DW-1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (DW-1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 track_en = 1'b0;
    logic                 freeze = 1'b0;
    logic signed [DW-1:0] in_a = '0;
    logic signed [DW-1:0] in_b = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_a;
    logic signed [DW-1:0] out_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    longint est_m [2];
    bit     exp_v;
    longint exp_y [2];
    string  exp_tag;

    always #2.5 clk = ~clk;

    dc_trim_stereo #(.DW(DW), .K(K)) u_dc_trim_stereo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .track_en(track_en),
        .freeze(freeze), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    function automatic longint sat(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic compare(input string tag);
        longint ga, gb;
        ga = longint'(out_a);
        gb = longint'(out_b);
        checks++;
        if (out_valid !== exp_v || ga != exp_y[0] || gb != exp_y[1]) begin
            errors++;
            $display("FAIL %s: got v=%0b a=%0d b=%0d expected v=%0b a=%0d b=%0d",
                     tag, out_valid, ga, gb, exp_v, exp_y[0], exp_y[1]);
        end
    endtask

    // one clock: check what the last edge produced, then drive the next inputs
    task automatic cyc(input bit v, input longint a, input longint b,
                       input bit en, input bit frz, input string tag);
        longint xs [2];
        @(negedge clk);
        compare(exp_tag);
        xs[0] = a;
        xs[1] = b;
        exp_v = v;
        if (v) begin
            for (int c = 0; c < 2; c++) begin
                longint ei;
                ei = est_m[c] >>> K;
                exp_y[c] = (en || frz) ? sat(xs[c] - ei) : xs[c];
                if (en && !frz)
                    est_m[c] = est_m[c] + (((xs[c] <<< K) - est_m[c]) >>> K);
            end
        end
        exp_tag  = tag;
        rst      = 1'b0;
        in_valid = v;
        track_en = en;
        freeze   = frz;
        in_a     = DW'(a);
        in_b     = DW'(b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        if (!rst) compare(exp_tag);
        rst = 1'b1;
        in_valid = 1'b0;
        est_m[0] = 0;
        est_m[1] = 0;
        exp_v = 1'b0;
        exp_y[0] = 0;
        exp_y[1] = 0;
        exp_tag = "R6 reset";
    endtask

    function automatic longint noise(input int i);
        return longint'((i * 37) % 201) - 100;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        est_m[0] = 0; est_m[1] = 0;
        exp_v = 0; exp_y[0] = 0; exp_y[1] = 0;
        exp_tag = "R6 reset";
        do_reset();
        do_reset();
        cyc(0, 0, 0, 0, 0, "R6 idle after reset");
        cyc(0, 0, 0, 0, 0, "R7 idle");
        // first sample after reset: zero estimate, output equals input
        cyc(1, 1234, -4321, 1, 0, "R6 zero estimate");
        cyc(0, 0, 0, 1, 0, "R7 hold between samples");
        // bypass
        for (int i = 0; i < 20; i++)
            cyc(1, 5000 + noise(i), -7000 + noise(i + 3), 0, 0, "R5 bypass");
        // tracking, distinct DC per channel, with gaps
        for (int i = 0; i < 400; i++)
            cyc((i % 3) != 2, 300000 + noise(i), -120000 + 3 * noise(i), 1, 0, "R1 track gaps");
        // mode bits toggled with no sample present
        cyc(0, 999, 999, 0, 1, "R8 idle toggle");
        cyc(0, 999, 999, 0, 0, "R8 idle toggle");
        cyc(1, 300010, -119990, 1, 0, "R8 next sample");
        // channel independence: A constant, B stepping
        for (int i = 0; i < 300; i++)
            cyc(1, 300000, -120000 + 50 * i, 1, 0, "R3 independence");
        do_reset();
        // long settle to large offsets of opposite sign
        for (int i = 0; i < 20000; i++)
            cyc(1, 6000000 + noise(i), -6000000 + noise(i + 7), 1, 0, "R9 settle");
        for (int i = 0; i < 50; i++)
            cyc(1, 6000000 + noise(i), -6000000 + noise(i + 7), 1, 1, "R9 freeze corrects");
        // freeze with enable low still subtracts
        for (int i = 0; i < 20; i++)
            cyc(1, 6000000 + 3 * noise(i), -6000000, 0, 1, "R4 freeze enable low");
        // saturation at both rails while frozen
        cyc(1, SMIN, SMAX, 1, 1, "R2 saturate rails");
        cyc(1, -8000000, 8000000, 0, 1, "R2 saturate rails");
        cyc(1, SMAX, SMIN, 1, 1, "R2 no overflow");
        // tracking resumes from held estimate
        for (int i = 0; i < 200; i++)
            cyc(1, noise(i), noise(i + 1), 1, 0, "R1 resume");
        // saturation while tracking
        cyc(1, SMIN, SMAX, 1, 0, "R2 track saturate");
        cyc(0, 0, 0, 1, 0, "R7 final");
        cyc(0, 0, 0, 1, 0, "R7 final");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule